// File: doc/BRIEF.md
# Receive Buffer Ownership Tracker

This block keeps one ownership state for each buffer in a bank of receive packet buffers. Two agents share the bank. The upper agent does protocol processing. The lower agent works next to the receive PHY. Each agent has its own request port, and a request carries a buffer index and a target state. The block checks each request against the moves that this agent alone is allowed to make. A legal request updates the state of that buffer. An illegal request leaves every state unchanged and raises an error pulse on the port of the agent that sent it.

A lower-agent request that moves a buffer to the ready state also produces a one-cycle notification to the upper agent, together with the index of the buffer. A combinational output tells the receive PHY side which buffer to fill next. That buffer is the lowest-index one that is owned by the lower agent and that is not being filled at the moment. The receive cycle has four states: unset, upper-owned, lower-owned and ready. There is no completion state. A buffer enters service once, at boot, through an init move. After that it goes round the three owned states.

Top module: `rx_own_tracker`

## Requirements
- R1: After reset, every buffer reads as unset (encoding 0). The ready pulse and both error pulses are low. No request can ever move a buffer back to unset.
- R2: A legal request updates the buffer state one cycle after the clock edge at which it was sampled. State encodings are: 0 unset, 1 upper-owned, 2 lower-owned, 3 ready. `bufState` holds buffer i in bits 2i+1:2i.
- R3: An upper request with target 2 on an unset buffer initialises it to lower-owned.
- R4: A lower request with target 3 on a lower-owned buffer makes it ready. In the next cycle `readyPulse` is high for exactly one cycle and `readyIdx` holds that buffer's index.
- R5: An upper request with target 1 on a ready buffer makes it upper-owned.
- R6: An upper request with target 2 on an upper-owned buffer returns it to lower-owned.
- R7: Any other request is ignored, and the sending agent's error output (`upErr` or `lowErr`) goes high for one cycle. This covers a wrong source state, a wrong target, target 0, a move that belongs to the other agent, and an index out of range. An agent with no request, or with a legal request, has its error output low in the next cycle.
- R8: When both agents make a request in the same cycle, the upper request is judged and applied first. The lower request is then judged against the state that results.
- R9: `freeValid` is high when some buffer is lower-owned and is not the buffer named by `fillIdx` while `fillActive` is high. `freeIdx` gives the lowest such index. Both outputs follow `bufState`, `fillActive` and `fillIdx` in the same cycle, with no register between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| upReqValid | input | 1 | Upper agent request strobe |
| upReqIdx | input | 3 | Upper agent buffer index |
| upReqTarget | input | 2 | Upper agent target state |
| lowReqValid | input | 1 | Lower agent request strobe |
| lowReqIdx | input | 3 | Lower agent buffer index |
| lowReqTarget | input | 2 | Lower agent target state |
| fillActive | input | 1 | The receive PHY is filling a buffer |
| fillIdx | input | 3 | Index of the buffer being filled |
| bufState | output | 16 | Packed states, 2 bits per buffer |
| readyPulse | output | 1 | One-cycle notice that a buffer became ready |
| readyIdx | output | 3 | Index of the last buffer made ready |
| upErr | output | 1 | Upper request was rejected |
| lowErr | output | 1 | Lower request was rejected |
| freeValid | output | 1 | A fillable buffer exists |
| freeIdx | output | 3 | Lowest fillable buffer index |

## Verification
Inputs change at the falling edge. Every registered result (`bufState`, `readyPulse`, `readyIdx`, `upErr` and `lowErr`) is due one rising edge after the request it answers. The bench therefore updates its reference model at that rising edge and compares at the next falling edge. The free-buffer outputs have no register, so they are compared in that same window against the model state and the fill inputs that are still applied. Simultaneous requests to the same buffer are checked to make sure that the upper move is applied first.

// File: rtl/rx_own_pkg.sv
package rx_own_pkg;

  typedef enum logic [1:0] {
    OWN_UNSET = 2'd0,
    OWN_UPPER = 2'd1,
    OWN_LOWER = 2'd2,
    OWN_READY = 2'd3
  } ownState_t;

  typedef struct packed {
    logic      upWe;
    ownState_t upNext;
    logic      lowWe;
    ownState_t lowNext;
  } ownStrobe_t;

endpackage

// File: rtl/rx_own_ctrl.sv
module rx_own_ctrl
  import rx_own_pkg::*;
#(
  parameter int NUM_BUFS = 8,
  parameter int IDX_W    = $clog2(NUM_BUFS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             upReqValid,
  input  logic [IDX_W-1:0] upReqIdx,
  input  logic [1:0]       upReqTarget,
  input  logic             lowReqValid,
  input  logic [IDX_W-1:0] lowReqIdx,
  input  logic [1:0]       lowReqTarget,
  input  ownState_t        curStates [NUM_BUFS],
  output ownStrobe_t       strobe,
  output logic             readyPulse,
  output logic [IDX_W-1:0] readyIdx,
  output logic             upErr,
  output logic             lowErr
);

  ownState_t upCur, lowCur, upTgt, lowTgt;
  logic      upInRange, lowInRange, upLegal, lowLegal;

  always_comb begin
    upTgt      = ownState_t'(upReqTarget);
    lowTgt     = ownState_t'(lowReqTarget);
    upInRange  = int'(upReqIdx) < NUM_BUFS;
    lowInRange = int'(lowReqIdx) < NUM_BUFS;
    upCur      = upInRange ? curStates[upReqIdx] : OWN_UNSET;
    upLegal    = upReqValid && upInRange &&
                 (((upCur == OWN_UNSET) && (upTgt == OWN_LOWER)) ||
                  ((upCur == OWN_READY) && (upTgt == OWN_UPPER)) ||
                  ((upCur == OWN_UPPER) && (upTgt == OWN_LOWER)));
    // upper request goes first; lower sees its result
    if (upLegal && (upReqIdx == lowReqIdx))
      lowCur = upTgt;
    else
      lowCur = lowInRange ? curStates[lowReqIdx] : OWN_UNSET;
    lowLegal = lowReqValid && lowInRange &&
               (lowCur == OWN_LOWER) && (lowTgt == OWN_READY);

    strobe.upWe    = upLegal;
    strobe.upNext  = upTgt;
    strobe.lowWe   = lowLegal;
    strobe.lowNext = lowTgt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyPulse <= 1'b0;
      readyIdx   <= '0;
      upErr      <= 1'b0;
      lowErr     <= 1'b0;
    end else begin
      readyPulse <= lowLegal;
      if (lowLegal) readyIdx <= lowReqIdx;
      upErr      <= upReqValid && !upLegal;
      lowErr     <= lowReqValid && !lowLegal;
    end
  end

  p_ready_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    readyPulse |-> ($past(lowReqValid) && ($past(lowReqTarget) == 2'd3)));

  p_up_err_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    upErr |-> $past(upReqValid));

  p_low_err_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    lowErr |-> $past(lowReqValid));

endmodule

// File: rtl/rx_own_dp.sv
module rx_own_dp
  import rx_own_pkg::*;
#(
  parameter int NUM_BUFS = 8,
  parameter int IDX_W    = $clog2(NUM_BUFS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ownStrobe_t       strobe,
  input  logic [IDX_W-1:0] upIdx,
  input  logic [IDX_W-1:0] lowIdx,
  input  logic             fillActive,
  input  logic [IDX_W-1:0] fillIdx,
  output ownState_t        states [NUM_BUFS],
  output logic             freeValid,
  output logic [IDX_W-1:0] freeIdx
);

  for (genvar g = 0; g < NUM_BUFS; g++) begin : gBuf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        states[g] <= OWN_UNSET;
      else if (strobe.lowWe && (int'(lowIdx) == g))
        states[g] <= strobe.lowNext;
      else if (strobe.upWe && (int'(upIdx) == g))
        states[g] <= strobe.upNext;
    end

    p_never_unset_r1: assert property (@(posedge clk) disable iff (!rstN)
      (states[g] != OWN_UNSET) |=> (states[g] != OWN_UNSET));
  end

  always_comb begin
    freeValid = 1'b0;
    freeIdx   = '0;
    for (int i = NUM_BUFS - 1; i >= 0; i--) begin
      if ((states[i] == OWN_LOWER) && !(fillActive && (int'(fillIdx) == i))) begin
        freeValid = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
  end

  p_free_lower_r9: assert property (@(posedge clk) disable iff (!rstN)
    freeValid |-> (states[freeIdx] == OWN_LOWER));

  p_free_not_filling_r9: assert property (@(posedge clk) disable iff (!rstN)
    (freeValid && fillActive) |-> (freeIdx != fillIdx));

endmodule

// File: rtl/rx_own_tracker.sv
module rx_own_tracker
  import rx_own_pkg::*;
#(
  parameter int NUM_BUFS = 8,
  parameter int IDX_W    = $clog2(NUM_BUFS),
  localparam int STATE_BITS = 2 * NUM_BUFS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  upReqValid,
  input  logic [IDX_W-1:0]      upReqIdx,
  input  logic [1:0]            upReqTarget,
  input  logic                  lowReqValid,
  input  logic [IDX_W-1:0]      lowReqIdx,
  input  logic [1:0]            lowReqTarget,
  input  logic                  fillActive,
  input  logic [IDX_W-1:0]      fillIdx,
  output logic [STATE_BITS-1:0] bufState,
  output logic                  readyPulse,
  output logic [IDX_W-1:0]      readyIdx,
  output logic                  upErr,
  output logic                  lowErr,
  output logic                  freeValid,
  output logic [IDX_W-1:0]      freeIdx
);

  ownStrobe_t strobe;
  ownState_t  states [NUM_BUFS];

  rx_own_ctrl #(.NUM_BUFS(NUM_BUFS), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .upReqValid(upReqValid), .upReqIdx(upReqIdx), .upReqTarget(upReqTarget),
    .lowReqValid(lowReqValid), .lowReqIdx(lowReqIdx), .lowReqTarget(lowReqTarget),
    .curStates(states), .strobe(strobe),
    .readyPulse(readyPulse), .readyIdx(readyIdx),
    .upErr(upErr), .lowErr(lowErr)
  );

  rx_own_dp #(.NUM_BUFS(NUM_BUFS), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .upIdx(upReqIdx), .lowIdx(lowReqIdx),
    .fillActive(fillActive), .fillIdx(fillIdx),
    .states(states), .freeValid(freeValid), .freeIdx(freeIdx)
  );

  for (genvar g = 0; g < NUM_BUFS; g++) begin : gPack
    assign bufState[2*g +: 2] = states[g];
  end

endmodule

// File: tb/rx_own_tracker_test.sv
module rx_own_tracker_test;

  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       upReqValid = 1'b0, lowReqValid = 1'b0, fillActive = 1'b0;
  logic [2:0] upReqIdx = '0, lowReqIdx = '0, fillIdx = '0;
  logic [1:0] upReqTarget = '0, lowReqTarget = '0;
  logic [15:0] bufState;
  logic       readyPulse, upErr, lowErr, freeValid;
  logic [2:0] readyIdx, freeIdx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int  mSt [N];
  bit  mReady, mUpErr, mLowErr;
  int  mReadyIdx;

  always #10 clk = ~clk;

  rx_own_tracker uut (
    .clk(clk), .rstN(rstN),
    .upReqValid(upReqValid), .upReqIdx(upReqIdx), .upReqTarget(upReqTarget),
    .lowReqValid(lowReqValid), .lowReqIdx(lowReqIdx), .lowReqTarget(lowReqTarget),
    .fillActive(fillActive), .fillIdx(fillIdx),
    .bufState(bufState), .readyPulse(readyPulse), .readyIdx(readyIdx),
    .upErr(upErr), .lowErr(lowErr), .freeValid(freeValid), .freeIdx(freeIdx)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    int q[$];
    for (int i = 0; i < N; i++)
      check(tag, $sformatf("state of buffer %0d", i), int'(bufState[2*i +: 2]), mSt[i]);
    check("R4", "readyPulse", int'(readyPulse), int'(mReady));
    if (mReady) check("R4", "readyIdx", int'(readyIdx), mReadyIdx);
    check("R7", "upErr", int'(upErr), int'(mUpErr));
    check("R7", "lowErr", int'(lowErr), int'(mLowErr));
    for (int i = 0; i < N; i++)
      if (mSt[i] == 2 && !(fillActive && int'(fillIdx) == i)) q.push_back(i);
    check("R9", "freeValid", int'(freeValid), int'(q.size() > 0));
    if (q.size() > 0) check("R9", "freeIdx", int'(freeIdx), q[0]);
  endtask

  task automatic step(string tag, bit uv, int ui, int ut, bit lv, int li, int lt,
                      bit fa = 0, int fi = 0);
    bit ok;
    upReqValid = uv; upReqIdx = 3'(ui); upReqTarget = 2'(ut);
    lowReqValid = lv; lowReqIdx = 3'(li); lowReqTarget = 2'(lt);
    fillActive = fa; fillIdx = 3'(fi);
    @(posedge clk);
    // reference: upper first, then lower on the updated picture
    mUpErr = 0; mLowErr = 0; mReady = 0;
    if (uv) begin
      ok = (mSt[ui] == 0 && ut == 2) || (mSt[ui] == 3 && ut == 1) ||
           (mSt[ui] == 1 && ut == 2);
      if (ok) mSt[ui] = ut; else mUpErr = 1;
    end
    if (lv) begin
      ok = (mSt[li] == 2 && lt == 3);
      if (ok) begin mSt[li] = 3; mReady = 1; mReadyIdx = li; end
      else mLowErr = 1;
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) mSt[i] = 0;
    mReady = 0; mUpErr = 0; mLowErr = 0; mReadyIdx = 0;
    repeat (3) @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");

    // lower agent cannot touch an unset buffer; target 0 is refused
    step("R7", 0, 0, 0, 1, 0, 3);
    step("R1", 1, 2, 0, 0, 0, 0);
    // boot init of every buffer
    for (int i = 0; i < N; i++) step("R3", 1, i, 2, 0, 0, 0);
    // a second init on a lower-owned buffer is refused
    step("R7", 1, 3, 2, 0, 0, 0);
    // free buffer skips the one being filled
    step("R9", 0, 0, 0, 0, 0, 0, 1, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 1, 5);
    // receive cycle on buffer 0
    step("R4", 0, 0, 0, 1, 0, 3, 1, 0);
    step("R4", 0, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 1, 0, 1);          // lower cannot claim for upper
    step("R7", 1, 0, 2, 0, 0, 0);          // ready -> lower not allowed
    step("R5", 1, 0, 1, 0, 0, 0);
    step("R7", 1, 0, 3, 0, 0, 0);          // upper cannot make ready
    step("R6", 1, 0, 2, 0, 0, 0);
    step("R7", 0, 0, 0, 1, 4, 2);          // wrong target from lower
    // same-cycle pairs
    step("R8", 1, 1, 1, 1, 2, 3);          // buf1 lower: up illegal, low legal
    step("R8", 1, 2, 1, 1, 1, 3);          // up claims 2, low readies 1
    step("R8", 1, 1, 1, 1, 1, 3);          // up claims 1; low on 1 now illegal
    step("R8", 1, 1, 2, 1, 1, 3);          // return then ready in same cycle
    step("R4", 0, 0, 0, 1, 7, 3);
    // drain lower-owned buffers to check free selection and empty case
    for (int i = 3; i < 7; i++) step("R9", 0, 0, 0, 1, i, 3);
    step("R9", 0, 0, 0, 0, 0, 0, 1, 0);
    step("R9", 0, 0, 0, 1, 0, 3, 1, 3);
    step("R9", 0, 0, 0, 0, 0, 0);
    step("R5", 1, 7, 1, 0, 0, 0);
    step("R6", 1, 7, 2, 0, 0, 0, 1, 7);
    step("R2", 0, 0, 0, 0, 0, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule